// File: doc/BRIEF.md
# Accumulator Bit-Field Extractor with Position Pointer

This block pulls a right-justified bit field out of a wide accumulator. The top bit of the field is set by a stored position pointer, not by an operand. Each request supplies a size code that selects a field width from 1 to 32 bits. The block checks that enough accumulator bits sit at or below the pointer. If they do, it returns the field. If they do not, it returns zero and raises a failure flag.

In advancing mode, a successful extract moves the pointer down past the bits just consumed. This lets software walk a packed bit stream held in the accumulator. When the walk uses up the last bit (bit 0), the pointer wraps to the top bit position. A separate write port loads the pointer directly. All results appear on the outputs one clock after the request is sampled.

Top module: `acc_field_extract`

## Requirements
- R1: While reset is asserted and after it is released, `result` is 0, `fail` is 0 and `ptr` is 0.
- R2: A request with `size` <= `ptr` is valid. One clock later, `result` holds accumulator bits `ptr` down to `ptr`-`size`, with bit `ptr`-`size` at result bit 0 and the upper bits zero.
- R3: A valid request clears `fail` one clock later.
- R4: A request with `size` > `ptr` is invalid. One clock later, `result` is 0 and `fail` is 1.
- R5: A valid request with `adv_mode`=1 sets `ptr` to `ptr`-(`size`+1) one clock later, so successive requests walk down the accumulator.
- R6: A valid request with `adv_mode`=1 and `size` equal to `ptr` sets `ptr` to 63 (the top bit index).
- R7: A request with `adv_mode`=0, or any invalid request, leaves `ptr` unchanged.
- R8: When `ptr_we` is high, `ptr` takes `ptr_wdata` one clock later. This overrides an advance requested in the same cycle. That same request still extracts using the old pointer.
- R9: In a cycle without a request, `result` and `fail` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_we | input | 1 | Load the position pointer |
| ptr_wdata | input | 6 | Value loaded into the pointer |
| req | input | 1 | Extract request |
| size | input | 5 | Field width minus one |
| adv_mode | input | 1 | Move the pointer down after a valid extract |
| acc | input | 64 | Accumulator value |
| result | output | 32 | Right-justified extracted field |
| ptr | output | 6 | Current position pointer |
| fail | output | 1 | Last extract lacked enough bits |

## Verification
The hardest state to reach is the exact-exhaustion boundary. This is where `size` equals `ptr`, so the field ends on bit 0 and the next pointer must wrap to 63 rather than going negative. The stimulus reaches it in two ways. First, it loads the pointer directly and asks for a field that uses every remaining bit. Second, it chains two advancing extracts so the pointer arrives there through the block's own update. The bench also drives a load and an advancing request in the same cycle. This shows both that the load takes precedence and that the extract used the old pointer.

// File: rtl/afx_pkg.sv
package afx_pkg;
   localparam int unsigned AFX_ACC_W  = 64;
   localparam int unsigned AFX_SIZE_W = 5;

   typedef struct packed {
      logic       ok;
      logic [5:0] lo;
      logic [5:0] next_ptr;
   } afx_bound_t;
endpackage

// File: rtl/afx_bound.sv
module afx_bound #(
   parameter int unsigned PTR_W  = 6,
   parameter int unsigned SIZE_W = 5
) (
   input  logic [PTR_W-1:0]  ptr,
   input  logic [SIZE_W-1:0] size,
   output logic              ok,
   output logic [PTR_W-1:0]  lo,
   output logic [PTR_W-1:0]  next_ptr
);
   localparam logic [PTR_W-1:0] TOP_IDX = {PTR_W{1'b1}};

   logic [PTR_W-1:0] size_x;
   logic             exhausts;

   generate
      if (SIZE_W > PTR_W) begin : g_bad_width
         $error("afx_bound: SIZE_W must not exceed PTR_W");
      end
   endgenerate

   assign size_x   = PTR_W'(size);
   assign ok       = (size_x <= ptr);
   assign lo       = ptr - size_x;
   assign exhausts = (size_x == ptr);

   always_comb begin
      if (exhausts) next_ptr = TOP_IDX;
      else          next_ptr = lo - PTR_W'(1);
   end
endmodule

// File: rtl/afx_field.sv
module afx_field #(
   parameter int unsigned ACC_W  = 64,
   parameter int unsigned PTR_W  = 6,
   parameter int unsigned SIZE_W = 5,
   parameter int unsigned RES_W  = 32
) (
   input  logic [ACC_W-1:0]  acc,
   input  logic [PTR_W-1:0]  lo,
   input  logic [SIZE_W-1:0] size,
   output logic [RES_W-1:0]  field
);
   logic [ACC_W-1:0] shifted;

   generate
      if (RES_W != (1 << SIZE_W)) begin : g_bad_res
         $error("afx_field: RES_W must equal 2**SIZE_W");
      end
      if (RES_W > ACC_W) begin : g_bad_acc
         $error("afx_field: RES_W must not exceed ACC_W");
      end
   endgenerate

   assign shifted = acc >> lo;

   genvar gi;
   generate
      for (gi = 0; gi < RES_W; gi++) begin : g_mask
         assign field[gi] = shifted[gi] & (SIZE_W'(gi) <= size);
      end
   endgenerate
endmodule

// File: rtl/afx_ptr_reg.sv
module afx_ptr_reg #(
   parameter int unsigned PTR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_data,
   input  logic             adv_en,
   input  logic [PTR_W-1:0] adv_val,
   output logic [PTR_W-1:0] ptr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (wr_en)  ptr_q <= wr_data;
      else if (adv_en) ptr_q <= adv_val;
   end

   // R8: load wins
   a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> ptr_q == $past(wr_data));

   // R7: no write and no advance keeps the pointer
   a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!wr_en && !adv_en) |-> $stable(ptr_q));
endmodule

// File: rtl/acc_field_extract.sv
module acc_field_extract #(
   parameter int unsigned ACC_W  = afx_pkg::AFX_ACC_W,
   parameter int unsigned SIZE_W = afx_pkg::AFX_SIZE_W,
   parameter int unsigned PTR_W  = $clog2(ACC_W),
   parameter int unsigned RES_W  = 1 << SIZE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_we,
   input  logic [PTR_W-1:0]  ptr_wdata,
   input  logic              req,
   input  logic [SIZE_W-1:0] size,
   input  logic              adv_mode,
   input  logic [ACC_W-1:0]  acc,
   output logic [RES_W-1:0]  result,
   output logic [PTR_W-1:0]  ptr,
   output logic              fail
);
   generate
      if (ACC_W != (1 << PTR_W)) begin : g_bad_acc
         $error("acc_field_extract: ACC_W must equal 2**PTR_W");
      end
   endgenerate

   logic             ok;
   logic [PTR_W-1:0] lo;
   logic [PTR_W-1:0] next_ptr;
   logic [RES_W-1:0] field;
   logic             adv_en;

   afx_bound #(.PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_bound (
      .ptr(ptr), .size(size), .ok(ok), .lo(lo), .next_ptr(next_ptr)
   );

   afx_field #(.ACC_W(ACC_W), .PTR_W(PTR_W), .SIZE_W(SIZE_W), .RES_W(RES_W)) u_field (
      .acc(acc), .lo(lo), .size(size), .field(field)
   );

   assign adv_en = req && adv_mode && ok;

   afx_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr_en(ptr_we), .wr_data(ptr_wdata),
      .adv_en(adv_en), .adv_val(next_ptr), .ptr_q(ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         fail   <= 1'b0;
      end else if (req) begin
         result <= ok ? field : '0;
         fail   <= !ok;
      end
   end

   // R4: short request gives zero and failure
   a_r4_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req) && (PTR_W'($past(size)) > $past(ptr))) |-> (fail && result == '0));

   // R3: valid request clears failure
   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req) && (PTR_W'($past(size)) <= $past(ptr))) |-> !fail);

   // R6: exact exhaustion wraps to the top index
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req && adv_mode && !ptr_we) && (PTR_W'($past(size)) == $past(ptr)))
      |-> ptr == {PTR_W{1'b1}});

   // R9: idle cycles hold the outputs
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req) |-> ($stable(result) && $stable(fail)));
endmodule

// File: tb/acc_field_extract_bench.sv
`timescale 1ns/1ps
module acc_field_extract_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_we = 1'b0;
   logic [5:0]  ptr_wdata = '0;
   logic        req = 1'b0;
   logic [4:0]  size = '0;
   logic        adv_mode = 1'b0;
   logic [63:0] acc = '0;
   logic [31:0] result;
   logic [5:0]  ptr;
   logic        fail;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   acc_field_extract u_acc_field_extract (
      .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
      .req(req), .size(size), .adv_mode(adv_mode), .acc(acc),
      .result(result), .ptr(ptr), .fail(fail)
   );

   typedef struct packed {
      logic [5:0]  p0;
      logic [4:0]  sz;
      logic        adv;
      logic [63:0] a;
      logic [31:0] exp_res;
      logic        exp_fail;
      logic [5:0]  exp_ptr;
   } vec_t;

   localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;
   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{6'd63, 5'd31, 1'b1, PAT,   32'h0123_4567, 1'b0, 6'd31},
      '{6'd31, 5'd31, 1'b1, PAT,   32'h89AB_CDEF, 1'b0, 6'd63},
      '{6'd7,  5'd3,  1'b0, PAT,   32'h0000_000E, 1'b0, 6'd7 },
      '{6'd3,  5'd4,  1'b1, PAT,   32'h0000_0000, 1'b1, 6'd3 },
      '{6'd0,  5'd0,  1'b1, PAT,   32'h0000_0001, 1'b0, 6'd63},
      '{6'd11, 5'd7,  1'b1, PAT,   32'h0000_00DE, 1'b0, 6'd3 },
      '{6'd40, 5'd5,  1'b0, PAT,   32'h0000_002C, 1'b0, 6'd40},
      '{6'd0,  5'd31, 1'b0, PAT,   32'h0000_0000, 1'b1, 6'd0 },
      '{6'd62, 5'd31, 1'b1, '1,    32'hFFFF_FFFF, 1'b0, 6'd30}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic load_ptr(input logic [5:0] v);
      @(negedge clk);
      ptr_we = 1'b1; ptr_wdata = v;
      @(negedge clk);
      ptr_we = 1'b0;
   endtask

   task automatic do_req(input logic [4:0] s, input logic d, input logic [63:0] a);
      @(negedge clk);
      req = 1'b1; size = s; adv_mode = d; acc = a;
      @(negedge clk);
      req = 1'b0; acc = '0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 result in reset", result, 0);
      chk("R1 fail in reset", fail, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ptr after reset", ptr, 0);
      chk("R1 result after reset", result, 0);

      for (int i = 0; i < NV; i++) begin
         load_ptr(VECS[i].p0);
         do_req(VECS[i].sz, VECS[i].adv, VECS[i].a);
         chk($sformatf("R2/R4 result vec %0d", i), result, VECS[i].exp_res);
         chk($sformatf("R3/R4 fail vec %0d", i), fail, VECS[i].exp_fail);
         chk($sformatf("R5/R6/R7 ptr vec %0d", i), ptr, VECS[i].exp_ptr);
      end

      // R9: idle cycles hold result and fail
      repeat (3) @(negedge clk);
      chk("R9 result held", result, 32'hFFFF_FFFF);
      chk("R9 fail held", fail, 0);

      // R5 chained walk down then R6 wrap through own update
      load_ptr(6'd63);
      do_req(5'd15, 1'b1, PAT);
      chk("R5 chain step1 result", result, 32'h0123);
      chk("R5 chain step1 ptr", ptr, 47);
      do_req(5'd15, 1'b1, PAT);
      chk("R5 chain step2 result", result, 32'h4567);
      chk("R5 chain step2 ptr", ptr, 31);
      do_req(5'd31, 1'b1, PAT);
      chk("R6 chain wrap result", result, 32'h89AB_CDEF);
      chk("R6 chain wrap ptr", ptr, 63);

      // R4 then R3: failure then recovery
      load_ptr(6'd2);
      do_req(5'd9, 1'b1, PAT);
      chk("R4 fail set", fail, 1);
      chk("R7 invalid keeps ptr", ptr, 2);
      do_req(5'd2, 1'b0, PAT);
      chk("R3 fail cleared", fail, 0);
      chk("R2 low field", result, 32'h7);

      // R8: simultaneous load and advance
      load_ptr(6'd20);
      @(negedge clk);
      ptr_we = 1'b1; ptr_wdata = 6'd50;
      req = 1'b1; size = 5'd3; adv_mode = 1'b1; acc = PAT;
      @(negedge clk);
      ptr_we = 1'b0; req = 1'b0;
      chk("R8 load wins ptr", ptr, 50);
      chk("R8 extract used old ptr", result, 32'h5);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule